// File: doc/BRIEF.md
# Multi-Purpose Register Read Mode Controller

This block sits on the device side of a DDR3 command stream and models the multi-purpose-register read mode. It watches already-decoded commands, tracks whether every bank is closed and past its precharge recovery window, and reacts to mode-register writes aimed at the third extended mode register. Those writes turn the special read mode on or off and choose which location is read.

While the mode is on, each read, with or without auto-precharge, is redirected away from the array. The block answers it with a fixed calibration burst: on every data bit, beats alternate 0,1,0,1 across a burst of eight. Any other command in this mode is reported on a one-cycle error pulse and otherwise has no effect. The error pulse also reports:

- an enable attempted while a bank is busy,
- a mode-register write with reserved bits set,
- a read of a reserved location,
- a read issued before the previous burst has finished.

The memory array and its timing are not modelled.

Top module: `mpr_read_ctrl`

## Requirements
- R1: After reset, `mpr_active_o`, `rd_valid_o` and `err_o` are all 0.
- R2: A command code 8 (mode-register write) with `ba_i` = 3'b011 and `addr_i[15:3]` all zero sets the mode from `addr_i[2]`. A value of 1 enables the mode and stores `addr_i[1:0]` as the location. A value of 0 disables the mode, and `addr_i[1:0]` is then ignored. A mode-register write with any other `ba_i` leaves the mode unchanged. `mpr_active_o` follows on the edge that samples the command.
- R3: A write to that register with any of `addr_i[15:3]` nonzero raises `err_o` and changes neither the mode nor the location.
- R4: An enable is accepted only when all of the following hold. No bank is open, where code 1 opens bank `ba_i` and codes 6, 3 and 5 close bank `ba_i`. Code 7 closes all banks. At least T_RP cycles have passed since the last closing command. Otherwise the enable raises `err_o` and the mode stays off.
- R5: In the mode, a read (code 2 or 3) at location 0 produces `rd_valid_o` for exactly 8 consecutive cycles. The first of these cycles follows RD_LAT clock edges after the edge that samples the read. On beat i, every bit of `rd_data_o` equals i mod 2.
- R6: A read at location 1, 2 or 3 raises `err_o` and yields 8 valid beats of all-zero data.
- R7: In the mode, only these commands are legal:
  - code 0 (no operation),
  - code 2 (read),
  - code 3 (read with auto-precharge),
  - a write to that mode register.
  Every other code is flagged on `err_o`, including refresh 9, power-down 10, self-refresh 11, calibration 12, the unused codes 13 to 15, and mode-register writes to other registers. A flagged command leaves the mode and bank state unchanged.
- R8: In the mode, a read issued fewer than 8 cycles after the last accepted read raises `err_o` and produces no burst.
- R9: Asserting reset while the mode is on turns the mode off.
- R10: Reads issued while the mode is off produce no `rd_valid_o`.
- R11: `err_o` is high for exactly the cycle after the edge that samples an offending command, and falls when the next command is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Decoded command code |
| ba_i | input | 3 | Bank address / mode-register select |
| addr_i | input | 16 | Address bus |
| rd_data_o | output | 8 | Read data beat |
| rd_valid_o | output | 1 | Read data valid |
| mpr_active_o | output | 1 | Special read mode is on |
| err_o | output | 1 | One-cycle error pulse |

## Verification
The bench probes the precharge recovery window one cycle short of and exactly at T_RP, for each bank and each closing command. An off-by-one counter would accept the early enable or reject the legal one. It sweeps all sixteen command codes inside the mode, each reserved address bit, and every location. A design that let a flagged activate reach the bank tracker would then refuse the next enable. It checks burst timing beat by beat, so a wrong read latency or an inverted alternating pattern shows up as a shifted or flipped beat. It also checks that disabling the mode with location bits set stays silent, and that reset drops the mode.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_RDA  = 4'd3,
        CMD_WR   = 4'd4,
        CMD_WRA  = 4'd5,
        CMD_PRE  = 4'd6,
        CMD_PREA = 4'd7,
        CMD_MRS  = 4'd8,
        CMD_REF  = 4'd9,
        CMD_PDE  = 4'd10,
        CMD_SRE  = 4'd11,
        CMD_ZQC  = 4'd12
    } cmd_e;

    localparam int unsigned MODE_REG_SEL = 3;
    localparam int unsigned LOC_PATTERN  = 0;

endpackage

// File: rtl/mpr_bank_track.sv
module mpr_bank_track
    import mpr_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned T_RP      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         upd_i,
    input  logic [3:0]                   cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
    output logic                         idle_o
);

    localparam int unsigned RP_W = $clog2(T_RP + 1);

    typedef struct packed {
        logic [NUM_BANKS-1:0] open;
        logic [RP_W-1:0]      rp;
    } bank_s;

    bank_s s_d, s_q;
    logic  close_any;

    always_comb begin
        s_d       = s_q;
        close_any = upd_i && (cmd_i == CMD_PRE || cmd_i == CMD_PREA ||
                              cmd_i == CMD_RDA || cmd_i == CMD_WRA);
        if (s_q.rp != '0) s_d.rp = s_q.rp - 1'b1;
        if (upd_i) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (ba_i == b[$clog2(NUM_BANKS)-1:0]) begin
                    if (cmd_i == CMD_ACT) s_d.open[b] = 1'b1;
                    if (cmd_i == CMD_PRE || cmd_i == CMD_RDA || cmd_i == CMD_WRA)
                        s_d.open[b] = 1'b0;
                end
            end
            if (cmd_i == CMD_PREA) s_d.open = '0;
        end
        if (close_any) s_d.rp = RP_W'(T_RP - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign idle_o = (s_q.open == '0) && (s_q.rp == '0);

    // R4: recovery window counts down one per cycle unless reloaded
    p_rp_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rp != '0 && !close_any) |=> (s_q.rp == RP_W'($past(s_q.rp) - 1'b1)));

    // R4: an activate leaves the banks non-idle
    p_act_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && cmd_i == CMD_ACT) |=> !idle_o);

endmodule

// File: rtl/mpr_mode_reg.sv
module mpr_mode_reg #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              idle_i,
    output logic              active_o,
    output logic [1:0]        loc_o,
    output logic              err_rsvd_o,
    output logic              err_busy_o
);

    typedef struct packed {
        logic       active;
        logic [1:0] loc;
    } mode_s;

    mode_s s_d, s_q;
    logic  rsvd_bad;
    logic  want_on;

    always_comb begin
        s_d        = s_q;
        rsvd_bad   = |addr_i[ADDR_W-1:3];
        want_on    = addr_i[2];
        err_rsvd_o = wr_i && rsvd_bad;
        err_busy_o = wr_i && !rsvd_bad && want_on && !s_q.active && !idle_i;
        if (wr_i && !rsvd_bad) begin
            if (!want_on) begin
                s_d.active = 1'b0;
            end else if (s_q.active || idle_i) begin
                s_d.active = 1'b1;
                s_d.loc    = addr_i[1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.active;
    assign loc_o    = s_q.loc;

    // R4: the mode only turns on when the banks were idle
    p_enable_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> $past(idle_i));

    // R3: a write with reserved bits set changes nothing
    p_rsvd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && |addr_i[ADDR_W-1:3]) |=> ($stable(active_o) && $stable(loc_o)));

endmodule

// File: rtl/mpr_burst_gen.sv
module mpr_burst_gen #(
    parameter int unsigned DQ_W      = 8,
    parameter int unsigned RD_LAT    = 5,
    parameter int unsigned BURST_LEN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch_i,
    input  logic            zero_i,
    output logic            valid_o,
    output logic [DQ_W-1:0] data_o
);

    localparam int unsigned BEAT_W = $clog2(BURST_LEN);
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

    typedef struct packed {
        logic [RD_LAT-1:0] pipe_v;
        logic [RD_LAT-1:0] pipe_z;
        logic              active;
        logic              zero;
        logic [BEAT_W-1:0] beat;
    } burst_s;

    burst_s s_d, s_q;
    logic   start;

    always_comb begin
        s_d = s_q;
        for (int i = RD_LAT - 1; i > 0; i--) begin
            s_d.pipe_v[i] = s_q.pipe_v[i-1];
            s_d.pipe_z[i] = s_q.pipe_z[i-1];
        end
        s_d.pipe_v[0] = launch_i;
        s_d.pipe_z[0] = zero_i;
        start = s_q.pipe_v[RD_LAT-1];
        if (s_q.active) begin
            if (s_q.beat == LAST) s_d.active = 1'b0;
            else                  s_d.beat   = s_q.beat + 1'b1;
        end
        if (start) begin
            s_d.active = 1'b1;
            s_d.beat   = '0;
            s_d.zero   = s_q.pipe_z[RD_LAT-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o = s_q.active;
    assign data_o  = (s_q.active && !s_q.zero) ? {DQ_W{s_q.beat[0]}} : '0;

    // R5: once a burst runs, it steps through consecutive beats
    p_burst_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.beat != LAST) |=>
            (s_q.active && s_q.beat == BEAT_W'($past(s_q.beat) + 1'b1)));

endmodule

// File: rtl/mpr_read_ctrl.sv
module mpr_read_ctrl
    import mpr_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DQ_W      = 8,
    parameter int unsigned RD_LAT    = 5,
    parameter int unsigned BURST_LEN = 8,
    parameter int unsigned T_RP      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [3:0]                   cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
    input  logic [ADDR_W-1:0]            addr_i,
    output logic [DQ_W-1:0]              rd_data_o,
    output logic                         rd_valid_o,
    output logic                         mpr_active_o,
    output logic                         err_o
);

    localparam int unsigned BA_W  = $clog2(NUM_BANKS);
    localparam int unsigned GAP_W = $clog2(BURST_LEN);

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic             err;
    } ctl_s;

    ctl_s s_d, s_q;

    logic       is_rd, mr3_wr, legal_mpr, illegal, accept, too_soon, loc_err;
    logic       bank_idle, err_rsvd, err_busy;
    logic [1:0] loc;

    always_comb begin
        is_rd     = (cmd_i == CMD_RD) || (cmd_i == CMD_RDA);
        mr3_wr    = (cmd_i == CMD_MRS) && (ba_i == BA_W'(MODE_REG_SEL));
        legal_mpr = (cmd_i == CMD_NOP) || is_rd || mr3_wr;
        illegal   = mpr_active_o && !legal_mpr;
        accept    = mpr_active_o && is_rd && (s_q.gap == '0);
        too_soon  = mpr_active_o && is_rd && (s_q.gap != '0);
        loc_err   = accept && (loc != 2'(LOC_PATTERN));

        s_d = s_q;
        if (accept)              s_d.gap = GAP_W'(BURST_LEN - 1);
        else if (s_q.gap != '0)  s_d.gap = s_q.gap - 1'b1;
        s_d.err = illegal || too_soon || loc_err || err_rsvd || err_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err_o = s_q.err;

    mpr_bank_track #(
        .NUM_BANKS (NUM_BANKS),
        .T_RP      (T_RP)
    ) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (!mpr_active_o),
        .cmd_i  (cmd_i),
        .ba_i   (ba_i),
        .idle_o (bank_idle)
    );

    mpr_mode_reg #(
        .ADDR_W (ADDR_W)
    ) i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (mr3_wr),
        .addr_i     (addr_i),
        .idle_i     (bank_idle),
        .active_o   (mpr_active_o),
        .loc_o      (loc),
        .err_rsvd_o (err_rsvd),
        .err_busy_o (err_busy)
    );

    mpr_burst_gen #(
        .DQ_W      (DQ_W),
        .RD_LAT    (RD_LAT),
        .BURST_LEN (BURST_LEN)
    ) i_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (accept),
        .zero_i   (loc != 2'(LOC_PATTERN)),
        .valid_o  (rd_valid_o),
        .data_o   (rd_data_o)
    );

    // R7: a non-read command in the mode is flagged on the next cycle
    p_illegal_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mpr_active_o && !legal_mpr) |=> err_o);

    // R7: a flagged command leaves the mode on
    p_illegal_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mpr_active_o && !legal_mpr) |=> mpr_active_o);

    // R8: an early read is flagged
    p_early_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mpr_active_o && is_rd && s_q.gap != '0) |=> err_o);

    // R11: a legal command outside the mode raises no error
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mpr_active_o && !mr3_wr) |=> !err_o);

endmodule

// File: tb/test_mpr_read_ctrl.sv
module test_mpr_read_ctrl;

    localparam int RD_LAT = 5;
    localparam int BL     = 8;
    localparam int T_RP   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd = '0;
    logic [2:0]  ba = '0;
    logic [15:0] addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid, mpr_active, err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mpr_read_ctrl #(
        .NUM_BANKS (8), .ADDR_W (16), .DQ_W (8),
        .RD_LAT (RD_LAT), .BURST_LEN (BL), .T_RP (T_RP)
    ) i_mpr_read_ctrl (
        .clk (clk), .rst_n (rst_n), .cmd_i (cmd), .ba_i (ba), .addr_i (addr),
        .rd_data_o (rd_data), .rd_valid_o (rd_valid),
        .mpr_active_o (mpr_active), .err_o (err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [2:0] b, input logic [15:0] a);
        cmd = c; ba = b; addr = a;
        @(negedge clk);
        cmd = '0; ba = '0; addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mpr_on(input logic [1:0] loc);
        issue(4'd8, 3'd3, {13'd0, 1'b1, loc});
    endtask

    task automatic mpr_off();
        issue(4'd8, 3'd3, 16'd0);
    endtask

    task automatic read_burst(input logic [3:0] c, input bit zero, input string req);
        issue(c, 3'd0, 16'd0);
        chk(req, {31'd0, err}, {31'd0, zero});
        for (int i = 0; i < RD_LAT - 1; i++) begin
            @(negedge clk);
            chk(req, {31'd0, rd_valid}, 32'd0);
        end
        for (int beat = 0; beat < BL; beat++) begin
            @(negedge clk);
            chk(req, {31'd0, rd_valid}, 32'd1);
            chk(req, {24'd0, rd_data}, (zero || beat % 2 == 0) ? 32'd0 : 32'hFF);
        end
        @(negedge clk);
        chk(req, {31'd0, rd_valid}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        // R1 reset state
        chk("R1", {29'd0, mpr_active, rd_valid, err}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        chk("R1", {29'd0, mpr_active, rd_valid, err}, 32'd0);

        // R10 reads outside the mode produce nothing
        issue(4'd2, 3'd0, 16'd0);
        for (int i = 0; i < RD_LAT + BL + 2; i++) begin
            chk("R10", {31'd0, rd_valid}, 32'd0);
            @(negedge clk);
        end

        // R2 other mode registers do not enable
        for (int b = 0; b < 8; b++) begin
            if (b != 3) begin
                issue(4'd8, 3'(b), 16'h0004);
                chk("R2", {31'd0, mpr_active}, 32'd0);
            end
        end

        // R2 / R5 enable and read the pattern, both read codes
        mpr_on(2'd0);
        chk("R2", {30'd0, mpr_active, err}, 32'd2);
        read_burst(4'd2, 1'b0, "R5");
        read_burst(4'd3, 1'b0, "R5");

        // R2 disable with location bits set is ignored and silent
        issue(4'd8, 3'd3, 16'h0003);
        chk("R2", {30'd0, mpr_active, err}, 32'd0);
        mpr_on(2'd0);
        read_burst(4'd2, 1'b0, "R2");

        // R6 reserved locations
        for (int l = 1; l < 4; l++) begin
            mpr_on(2'(l));
            chk("R6", {31'd0, mpr_active}, 32'd1);
            read_burst(4'd2, 1'b1, "R6");
            @(negedge clk);
            chk("R11", {31'd0, err}, 32'd0);
        end
        mpr_on(2'd0);

        // R8 reads closer than a burst apart
        for (int gap = 1; gap <= BL; gap++) begin
            issue(4'd2, 3'd0, 16'd0);
            idle(gap - 1);
            issue(4'd2, 3'd0, 16'd0);
            chk("R8", {31'd0, err}, (gap < BL) ? 32'd1 : 32'd0);
            idle(RD_LAT + 2 * BL);
        end

        // R7 sweep of every command code inside the mode
        for (int c = 0; c < 16; c++) begin
            issue(4'(c), 3'd0, 16'd0);
            chk("R7", {31'd0, err}, (c == 0 || c == 2 || c == 3) ? 32'd0 : 32'd1);
            chk("R7", {31'd0, mpr_active}, 32'd1);
            idle(BL + 2);
        end
        idle(RD_LAT + BL);

        // R7 flagged activate does not open a bank
        issue(4'd1, 3'd2, 16'd0);
        chk("R7", {31'd0, err}, 32'd1);
        mpr_off();
        mpr_on(2'd0);
        chk("R7", {30'd0, mpr_active, err}, 32'd2);
        mpr_off();

        // R3 reserved address bits
        for (int j = 3; j < 16; j++) begin
            issue(4'd8, 3'd3, 16'(1 << j) | 16'h0004);
            chk("R3", {30'd0, mpr_active, err}, 32'd1);
        end

        // R4 bank idle and recovery window, per bank and closing command
        for (int b = 0; b < 8; b++) begin
            logic [3:0] cl;
            cl = (b % 4 == 0) ? 4'd6 : (b % 4 == 1) ? 4'd7 : (b % 4 == 2) ? 4'd3 : 4'd5;
            issue(4'd1, 3'(b), 16'd0);
            mpr_on(2'd0);
            chk("R4", {30'd0, mpr_active, err}, 32'd1);
            issue(cl, 3'(b), 16'd0);
            idle(T_RP - 2);
            mpr_on(2'd0);
            chk("R4", {30'd0, mpr_active, err}, 32'd1);
            issue(cl, 3'(b), 16'd0);
            idle(T_RP - 1);
            mpr_on(2'd0);
            chk("R4", {30'd0, mpr_active, err}, 32'd2);
            mpr_off();
        end

        // R11 error is a single pulse
        mpr_on(2'd0);
        issue(4'd9, 3'd0, 16'd0);
        chk("R11", {31'd0, err}, 32'd1);
        @(negedge clk);
        chk("R11", {31'd0, err}, 32'd0);

        // R9 reset leaves the mode
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", {31'd0, mpr_active}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(4'd2, 3'd0, 16'd0);
        for (int i = 0; i < RD_LAT + BL; i++) begin
            chk("R9", {31'd0, rd_valid}, 32'd0);
            @(negedge clk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule